// File: doc/BRIEF.md
# Cartridge Bank Mapper with Decompression Trigger

This block sits between a host CPU bus and a cartridge ROM. It translates host read addresses into ROM addresses for two host regions. The first is a 32 KB-paged region found in the upper half of each low bank. The second is a linear region covering host banks 0xC0 to 0xFF. Four bank registers select the megabyte each translation uses. These registers and two channel-enable masks live in an eight-byte I/O window.

The block also watches host writes to the host's DMA channel registers and keeps its own copy of them. When software writes the second enable mask, the block looks for the lowest eligible channel. If it finds one, it arms a trigger address and a transfer count taken from that channel's copy, and it tells an external decompressor where its stream begins. Host reads that hit the armed address are then answered with decompressed bytes, not ROM bytes, until the count runs out.

Every read is answered through a valid pulse. ROM and decompressor accesses each use a one-cycle request and wait for their own valid strobe. The host must wait for `host_ready` before it issues a read.

Top module: `cart_bank_mapper`

## Requirements
- R1: After reset, bank registers 0..3 read back 0,1,2,3 and both enable masks read 0. Every shadow channel byte holds 0xFF, so setting all enable bits right after reset arms nothing.
- R2: The I/O window is host banks with bit 6 clear, at offsets 0x4800..0x4807. Offsets 0 and 1 hold enable masks A and B, and offsets 4..7 hold bank registers 0..3. Reads of offsets 0 and 4..7 return the stored byte, and offsets 1, 2 and 3 read 0. An I/O read is answered with `rd_valid` one cycle after it is accepted.
- R3: A read in host banks 0xC0..0xFF uses host bits [21:20] to pick bank register r. The ROM address is {r[2:0], host[19:0]}.
- R4: A read in a bank with bit 6 clear, at an address with bit 15 set, uses host bits [22:21] to pick register i. The megabyte is r[2:0] when r[7] is set and i otherwise. Host bits [20:16] land in ROM bits [19:15], and host bits [14:0] land in ROM bits [14:0].
- R5: Writes in banks with bit 6 clear to low address 0x43c0 or 0x43c2..0x43c6 are copied into the shadow of channel c (bits [6:4]) at byte index (bits [2:0]). Banks 0x00 and 0x80 behave alike.
- R6: A write to offset 1 stores mask B and drops any armed trigger. It then arms the lowest channel whose bit is set in both masks and whose byte 0 ANDed with 0x88 equals 0x08. The trigger address is bytes 4:3:2 and the count is bytes 6:5. The block pulses `dec_start` with that address.
- R7: While armed, a linear-region read equal to the trigger address issues one `dec_req` pulse and returns `dec_data` once `dec_valid` arrives. Any other read goes to ROM.
- R8: Each trigger read decrements the count. The read that takes the count from 1 to 0 disarms the trigger. A count of 0 stands for 65536 reads, so it does not disarm on the first read.
- R9: A ROM read issues one `rom_req` pulse carrying `rom_addr`, and the block returns `rom_data` once `rom_valid` arrives. `rom_req` and `dec_req` are never high together.
- R10: When several channels qualify, the lowest-numbered one is armed.
- R11: A read outside the I/O window and both ROM regions, for example in host banks 0x40..0x7F, returns 0 one cycle later without any ROM or decompressor request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 24 | Host bus address |
| host_rd | input | 1 | Read request, accepted when host_ready is high |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | No read outstanding |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 8 | Read data |
| rom_req | output | 1 | ROM fetch request pulse |
| rom_addr | output | 23 | ROM byte address |
| rom_valid | input | 1 | ROM data valid |
| rom_data | input | 8 | ROM data |
| dec_start | output | 1 | Decompressor restart pulse |
| dec_start_addr | output | 24 | Stream start address |
| dec_req | output | 1 | Next decompressed byte request |
| dec_valid | input | 1 | Decompressed byte valid |
| dec_data | input | 8 | Decompressed byte |

## Verification
The embedded properties check, on every cycle, several timing relationships. They confirm that an I/O read is answered in the following cycle and that reserved offsets stay zero. They also confirm that a snooped write lands in the addressed shadow byte and that the two downstream request strobes never coincide. Finally, they confirm that a decompressor strobe is forwarded to the host and that the final counted read disarms the trigger. Other behaviours can only be shown by the bench's scenarios. These are the exact address arithmetic of both regions, the channel priority and the 0x88/0x08 qualification, the 65536 meaning of a zero count, and the reset contents of the shadow copy.

// File: rtl/cbm_pkg.sv
package cbm_pkg;
   typedef enum logic [2:0] {
      RG_NONE   = 3'd0,
      RG_IO     = 3'd1,
      RG_PAGED  = 3'd2,
      RG_LINEAR = 3'd3,
      RG_DMA    = 3'd4
   } region_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ROM  = 2'd1,
      ST_DEC  = 2'd2
   } rd_state_e;
endpackage

// File: rtl/cbm_io_regs.sv
module cbm_io_regs #(
   parameter int DW        = 8,
   parameter int NUM_BANKS = 4,
   parameter int OFF_W     = 3
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [OFF_W-1:0]                off,
   input  logic [DW-1:0]                   wdata,
   output logic [DW-1:0]                   en_a,
   output logic [DW-1:0]                   en_b,
   output logic [NUM_BANKS-1:0][DW-1:0]    bank_q,
   output logic [DW-1:0]                   rdata
);
   localparam int BSEL_W    = $clog2(NUM_BANKS);
   localparam int BANK_BASE = 1 << (OFF_W - 1);

   if (NUM_BANKS != 4) begin : g_bad_banks
      $error("cbm_io_regs: four bank registers are required");
   end
   if (OFF_W != 3) begin : g_bad_off
      $error("cbm_io_regs: window is eight bytes");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_a <= '0;
         en_b <= '0;
      end else if (wr_en) begin
         if (off == OFF_W'(0)) en_a <= wdata;
         if (off == OFF_W'(1)) en_b <= wdata;
      end
   end

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n)
            bank_q[g] <= DW'(g);
         else if (wr_en && off == OFF_W'(BANK_BASE + g))
            bank_q[g] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (off == OFF_W'(0))
         rdata = en_a;
      else if (off[OFF_W-1])
         rdata = bank_q[off[BSEL_W-1:0]];
   end

   // R2
   reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (off == OFF_W'(1) || off == OFF_W'(2) || off == OFF_W'(3)) |-> rdata == '0);
endmodule

// File: rtl/cbm_dma_shadow.sv
module cbm_dma_shadow #(
   parameter int       DW        = 8,
   parameter int       NUM_CH    = 8,
   parameter int       CH_BYTES  = 8,
   parameter int       TRIG_AW   = 24,
   parameter int       CNT_W     = 16,
   parameter logic [7:0] CTL_MASK  = 8'h88,
   parameter logic [7:0] CTL_MATCH = 8'h08
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap_en,
   input  logic [$clog2(NUM_CH)-1:0]     cap_ch,
   input  logic [$clog2(CH_BYTES)-1:0]   cap_reg,
   input  logic [DW-1:0]                 cap_data,
   input  logic [NUM_CH-1:0]             arm_mask,
   output logic                          arm_hit,
   output logic [TRIG_AW-1:0]            arm_addr,
   output logic [CNT_W-1:0]              arm_cnt
);
   localparam int CH_W  = $clog2(NUM_CH);
   localparam int ADDR_BYTES = TRIG_AW / DW;
   localparam int CNT_BYTES  = CNT_W / DW;

   if (ADDR_BYTES != 3 || CNT_BYTES != 2) begin : g_bad_fields
      $error("cbm_dma_shadow: trigger is 3 bytes and count 2 bytes");
   end
   if (CH_BYTES < 7) begin : g_bad_bytes
      $error("cbm_dma_shadow: a channel needs at least seven bytes");
   end

   logic [NUM_CH-1:0][CH_BYTES-1:0][DW-1:0] shadow;
   logic [NUM_CH-1:0]                       qual;
   logic [CH_W-1:0]                         sel;

   always_ff @(posedge clk) begin
      if (!rst_n)
         shadow <= '1;
      else if (cap_en)
         shadow[cap_ch][cap_reg] <= cap_data;
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_qual
      assign qual[g] = arm_mask[g] && ((shadow[g][0] & CTL_MASK) == CTL_MATCH);
   end

   always_comb begin
      arm_hit = 1'b0;
      sel     = '0;
      for (int c = NUM_CH - 1; c >= 0; c--) begin
         if (qual[c]) begin
            arm_hit = 1'b1;
            sel     = CH_W'(c);
         end
      end
   end

   assign arm_addr = {shadow[sel][4], shadow[sel][3], shadow[sel][2]};
   assign arm_cnt  = {shadow[sel][6], shadow[sel][5]};

   // R5
   shadow_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> shadow[$past(cap_ch)][$past(cap_reg)] == $past(cap_data));
endmodule

// File: rtl/cbm_xlate.sv
module cbm_xlate
   import cbm_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          HOST_AW   = 24,
   parameter int          ROM_AW    = 23,
   parameter int          NUM_BANKS = 4,
   parameter int          NUM_CH    = 8,
   parameter int          CH_BYTES  = 8,
   parameter logic [15:0] IO_BASE   = 16'h4800,
   parameter logic [7:0]  DMA_PAGE  = 8'h43
) (
   input  logic [HOST_AW-1:0]             addr,
   input  logic [NUM_BANKS-1:0][DW-1:0]   bank_q,
   output region_e                        region,
   output logic [ROM_AW-1:0]              rom_addr,
   output logic [2:0]                     io_off,
   output logic [$clog2(NUM_CH)-1:0]      dma_ch,
   output logic [$clog2(CH_BYTES)-1:0]    dma_reg
);
   localparam int MB_W   = ROM_AW - 20;
   localparam int BSEL_W = $clog2(NUM_BANKS);
   localparam int CH_W   = $clog2(NUM_CH);
   localparam int REG_W  = $clog2(CH_BYTES);

   if (HOST_AW != 24 || ROM_AW != 23) begin : g_bad_aw
      $error("cbm_xlate: 24-bit host and 23-bit ROM addresses expected");
   end
   if (NUM_CH > 8) begin : g_bad_ch
      $error("cbm_xlate: channel field is three bits");
   end

   logic [7:0]        hbank;
   logic [15:0]       lo;
   logic              dma_reg_ok;
   logic [BSEL_W-1:0] lsel, psel;
   logic [DW-1:0]     lreg, preg;
   logic [MB_W-1:0]   pbase;

   assign hbank = addr[23:16];
   assign lo    = addr[15:0];
   assign dma_reg_ok = (lo[3:0] == 4'd0) || (lo[3:0] >= 4'd2 && lo[3:0] <= 4'd6);

   always_comb begin
      region = RG_NONE;
      if (hbank[7:6] == 2'b11)
         region = RG_LINEAR;
      else if (!hbank[6]) begin
         if (lo[15])
            region = RG_PAGED;
         else if (lo[15:3] == IO_BASE[15:3])
            region = RG_IO;
         else if (lo[15:8] == DMA_PAGE && !lo[7] && dma_reg_ok)
            region = RG_DMA;
      end
   end

   assign lsel  = addr[21:20];
   assign psel  = addr[22:21];
   assign lreg  = bank_q[lsel];
   assign preg  = bank_q[psel];
   assign pbase = preg[7] ? preg[MB_W-1:0] : MB_W'(psel);

   always_comb begin
      if (region == RG_LINEAR)
         rom_addr = {lreg[MB_W-1:0], addr[19:0]};
      else
         rom_addr = {pbase, addr[20:16], addr[14:0]};
   end

   assign io_off  = lo[2:0];
   assign dma_ch  = CH_W'(lo[6:4]);
   assign dma_reg = REG_W'(lo[2:0]);
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
   import cbm_pkg::*;
#(
   parameter int          DW        = 8,
   parameter int          HOST_AW   = 24,
   parameter int          ROM_AW    = 23,
   parameter int          NUM_BANKS = 4,
   parameter int          NUM_CH    = 8,
   parameter int          CH_BYTES  = 8,
   parameter int          CNT_W     = 16,
   parameter logic [15:0] IO_BASE   = 16'h4800,
   parameter logic [7:0]  DMA_PAGE  = 8'h43
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [23:0]        host_addr,
   input  logic               host_rd,
   input  logic               host_wr,
   input  logic [7:0]         host_wdata,
   output logic               host_ready,
   output logic               rd_valid,
   output logic [7:0]         rd_data,
   output logic               rom_req,
   output logic [22:0]        rom_addr,
   input  logic               rom_valid,
   input  logic [7:0]         rom_data,
   output logic               dec_start,
   output logic [23:0]        dec_start_addr,
   output logic               dec_req,
   input  logic               dec_valid,
   input  logic [7:0]         dec_data
);
   localparam int CH_W  = $clog2(NUM_CH);
   localparam int REG_W = $clog2(CH_BYTES);

   if (DW != 8 || NUM_CH != DW) begin : g_bad_mask
      $error("cart_bank_mapper: one enable bit per channel in a byte");
   end

   region_e                       region;
   logic [ROM_AW-1:0]             xl_rom_addr;
   logic [2:0]                    io_off;
   logic [CH_W-1:0]               dma_ch;
   logic [REG_W-1:0]              dma_reg;
   logic [DW-1:0]                 en_a, en_b, io_rdata;
   logic [NUM_BANKS-1:0][DW-1:0]  bank_q;
   logic                          arm_hit;
   logic [HOST_AW-1:0]            arm_addr;
   logic [CNT_W-1:0]              arm_cnt;

   rd_state_e                     state;
   logic                          armed;
   logic [HOST_AW-1:0]            trig_addr;
   logic [CNT_W-1:0]              trig_cnt;

   logic io_wr, arm_evt, cap_en, rd_go, trig_hit;

   cbm_xlate #(
      .DW(DW), .HOST_AW(HOST_AW), .ROM_AW(ROM_AW), .NUM_BANKS(NUM_BANKS),
      .NUM_CH(NUM_CH), .CH_BYTES(CH_BYTES), .IO_BASE(IO_BASE), .DMA_PAGE(DMA_PAGE)
   ) u_xlate (
      .addr(host_addr), .bank_q(bank_q), .region(region), .rom_addr(xl_rom_addr),
      .io_off(io_off), .dma_ch(dma_ch), .dma_reg(dma_reg)
   );

   assign io_wr   = host_wr && region == RG_IO;
   assign arm_evt = io_wr && io_off == 3'd1;
   assign cap_en  = host_wr && region == RG_DMA;

   cbm_io_regs #(.DW(DW), .NUM_BANKS(NUM_BANKS), .OFF_W(3)) u_io (
      .clk(clk), .rst_n(rst_n), .wr_en(io_wr), .off(io_off), .wdata(host_wdata),
      .en_a(en_a), .en_b(en_b), .bank_q(bank_q), .rdata(io_rdata)
   );

   cbm_dma_shadow #(
      .DW(DW), .NUM_CH(NUM_CH), .CH_BYTES(CH_BYTES), .TRIG_AW(HOST_AW), .CNT_W(CNT_W)
   ) u_shadow (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .cap_ch(dma_ch), .cap_reg(dma_reg),
      .cap_data(host_wdata), .arm_mask(en_a & host_wdata),
      .arm_hit(arm_hit), .arm_addr(arm_addr), .arm_cnt(arm_cnt)
   );

   assign host_ready = state == ST_IDLE;
   assign rd_go      = host_rd && state == ST_IDLE;
   assign trig_hit   = armed && region == RG_LINEAR && host_addr == trig_addr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state          <= ST_IDLE;
         armed          <= 1'b0;
         trig_addr      <= '0;
         trig_cnt       <= '0;
         rd_valid       <= 1'b0;
         rd_data        <= '0;
         rom_req        <= 1'b0;
         rom_addr       <= '0;
         dec_req        <= 1'b0;
         dec_start      <= 1'b0;
         dec_start_addr <= '0;
      end else begin
         rd_valid  <= 1'b0;
         rom_req   <= 1'b0;
         dec_req   <= 1'b0;
         dec_start <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (rd_go) begin
                  if (trig_hit) begin
                     dec_req  <= 1'b1;
                     state    <= ST_DEC;
                     trig_cnt <= trig_cnt - CNT_W'(1);
                     if (trig_cnt == CNT_W'(1)) armed <= 1'b0;
                  end else if (region == RG_LINEAR || region == RG_PAGED) begin
                     rom_req  <= 1'b1;
                     rom_addr <= xl_rom_addr;
                     state    <= ST_ROM;
                  end else begin
                     rd_valid <= 1'b1;
                     rd_data  <= (region == RG_IO) ? io_rdata : '0;
                  end
               end
            end
            ST_ROM: begin
               if (rom_valid) begin
                  rd_valid <= 1'b1;
                  rd_data  <= rom_data;
                  state    <= ST_IDLE;
               end
            end
            ST_DEC: begin
               if (dec_valid) begin
                  rd_valid <= 1'b1;
                  rd_data  <= dec_data;
                  state    <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
         if (arm_evt) begin
            armed <= arm_hit;
            if (arm_hit) begin
               trig_addr      <= arm_addr;
               trig_cnt       <= arm_cnt;
               dec_start      <= 1'b1;
               dec_start_addr <= arm_addr;
            end
         end
      end
   end

   // R2
   io_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && region == RG_IO) |=> rd_valid);

   // R7
   dec_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DEC && dec_valid) |=> (rd_valid && rd_data == $past(dec_data) && host_ready));

   // R8
   last_read_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_go && trig_hit && trig_cnt == CNT_W'(1) && !host_wr) |=> !armed);

   // R9
   req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req |-> !dec_req);

   // R9
   rom_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rom_req |=> !rom_req);
endmodule

// File: tb/cart_bank_mapper_bench.sv
`timescale 1ns/1ps
module cart_bank_mapper_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [23:0] host_addr = '0;
   logic        host_rd = 1'b0, host_wr = 1'b0;
   logic [7:0]  host_wdata = '0;
   logic        host_ready, rd_valid, rom_req, dec_start, dec_req;
   logic [7:0]  rd_data;
   logic [22:0] rom_addr;
   logic [23:0] dec_start_addr;
   logic        rom_valid = 1'b0, dec_valid = 1'b0;
   logic [7:0]  rom_data = '0, dec_data = '0;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   cart_bank_mapper u_cart_bank_mapper (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
      .host_wr(host_wr), .host_wdata(host_wdata), .host_ready(host_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .rom_req(rom_req), .rom_addr(rom_addr),
      .rom_valid(rom_valid), .rom_data(rom_data), .dec_start(dec_start),
      .dec_start_addr(dec_start_addr), .dec_req(dec_req), .dec_valid(dec_valid),
      .dec_data(dec_data)
   );

   function automatic logic [7:0] rom_fn(input logic [23:0] a);
      return a[7:0] ^ {1'b0, a[22:16]};
   endfunction

   // external models, sampled on falling edges
   logic        rom_seen = 0, dec_seen = 0, start_seen = 0;
   logic [23:0] rom_last = '0, start_last = '0;
   int          rom_wait = 0, dec_wait = 0;
   logic [7:0]  dec_n = 8'hA0;

   always @(negedge clk) begin
      rom_valid = 1'b0;
      dec_valid = 1'b0;
      if (rom_wait > 0) begin
         rom_wait--;
         if (rom_wait == 0) begin rom_valid = 1'b1; rom_data = rom_fn(rom_last); end
      end
      if (dec_wait > 0) begin
         dec_wait--;
         if (dec_wait == 0) begin dec_valid = 1'b1; dec_data = dec_n; dec_n++; end
      end
      if (rom_req) begin rom_seen = 1; rom_last = {1'b0, rom_addr}; rom_wait = 2; end
      if (dec_req) begin dec_seen = 1; dec_wait = 3; end
      if (dec_start) begin start_seen = 1; start_last = dec_start_addr; end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [23:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
      @(negedge clk);
   endtask

   task automatic rd(input logic [23:0] a, output logic [7:0] d);
      @(negedge clk);
      while (!host_ready) @(negedge clk);
      rom_seen = 0; dec_seen = 0;
      host_addr = a; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      for (int t = 0; t < 40 && !rd_valid; t++) @(negedge clk);
      d = rd_valid ? rd_data : 8'hXX;
   endtask

   localparam logic [47:0] XV [0:7] = '{
      48'hC0ABCD_50ABCD, 48'hD54321_354321, 48'hEFFFFF_2FFFFF, 48'hF00000_700000,
      48'h008000_000000, 48'h3FFFFF_3FFFFF, 48'h8A9234_051234, 48'hA1C000_30C000
   };

   initial begin
      #(5.0 * 100000);
      errors++;
      $display("FAIL R7 watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic [7:0] exp_dec;
      exp_dec = 8'hA0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      for (int i = 0; i < 4; i++) begin
         rd(24'h004804 + 24'(i), d);
         chk("R1 bank reset", 32'(d), 32'(i));
      end
      rd(24'h004800, d); chk("R1 enable reset", 32'(d), 0);
      start_seen = 0;
      wr(24'h004800, 8'hFF); wr(24'h004801, 8'hFF);
      chk("R1 shadow FF no arm", 32'(start_seen), 0);
      rd(24'hC00000, d);
      chk("R1 read goes to ROM", 32'(rom_seen), 1);
      chk("R1 no decompress", 32'(dec_seen), 0);

      // R2 window reads
      rd(24'h004800, d); chk("R2 mask A readback", 32'(d), 32'hFF);
      rd(24'h004801, d); chk("R2 mask B reads 0", 32'(d), 0);
      rd(24'h004802, d); chk("R2 offset 2 reads 0", 32'(d), 0);

      // R4 paged, bit 7 clear uses select as base
      rd(24'h208000, d); chk("R4 default base", 32'(rom_last), 32'h100000);

      wr(24'h004804, 8'h05); wr(24'h004805, 8'h83);
      wr(24'h004806, 8'h02); wr(24'h004807, 8'h87);
      rd(24'h004805, d); chk("R2 bank readback", 32'(d), 32'h83);

      // R3 R4 R9 translation table
      for (int i = 0; i < 8; i++) begin
         rd(XV[i][47:24], d);
         if (XV[i][47:46] == 2'b11) chk("R3 linear addr", 32'(rom_last), 32'(XV[i][23:0]));
         else                      chk("R4 paged addr", 32'(rom_last), 32'(XV[i][23:0]));
         chk("R9 rom data", 32'(d), 32'(rom_fn(XV[i][23:0])));
      end

      // R6 arming: ch2 eligible, ch5 ctl 0x01, ch6 ctl 0x88
      wr(24'h004320, 8'h08); wr(24'h004322, 8'h34); wr(24'h004323, 8'h12);
      wr(24'h004324, 8'hC4); wr(24'h004325, 8'h03); wr(24'h004326, 8'h00);
      wr(24'h004350, 8'h01); wr(24'h004360, 8'h88);
      start_seen = 0;
      wr(24'h004801, 8'h60);
      chk("R6 bad control not armed", 32'(start_seen), 0);
      wr(24'h004801, 8'h64);
      chk("R6 start pulse", 32'(start_seen), 1);
      chk("R6 start address", 32'(start_last), 32'hC41234);

      // R7 R8 three counted reads
      for (int k = 0; k < 3; k++) begin
         rd(24'hC41234, d);
         chk("R7 decompressor used", 32'(dec_seen), 1);
         chk("R7 decompressed data", 32'(d), 32'(exp_dec));
         exp_dec++;
         if (k == 0) begin
            rd(24'hC41235, d);
            chk("R7 neighbour from ROM", 32'(rom_seen), 1);
         end
      end
      rd(24'hC41234, d);
      chk("R8 disarmed after count", 32'(dec_seen), 0);
      chk("R8 ROM after count", 32'(d), 32'(rom_fn(24'h541234)));

      // R10 priority, R5 capture through bank 0x80, R8 zero count
      wr(24'h004310, 8'h08); wr(24'h004312, 8'h10); wr(24'h004313, 8'h00);
      wr(24'h004314, 8'hC0); wr(24'h004315, 8'h00); wr(24'h004316, 8'h00);
      wr(24'h804330, 8'h0C); wr(24'h804332, 8'h00); wr(24'h804333, 8'h00);
      wr(24'h804334, 8'hFF); wr(24'h804335, 8'h02); wr(24'h804336, 8'h00);
      start_seen = 0;
      wr(24'h004801, 8'h0A);
      chk("R10 lowest channel wins", 32'(start_last), 32'hC00010);
      for (int k = 0; k < 2; k++) begin
         rd(24'hC00010, d);
         chk("R8 zero count keeps armed", 32'(dec_seen), 1);
         chk("R7 data", 32'(d), 32'(exp_dec));
         exp_dec++;
      end
      wr(24'h004801, 8'h08);
      chk("R5 mirror bank capture", 32'(start_last), 32'hFF0000);
      rd(24'hC00010, d);
      chk("R6 rearm drops old trigger", 32'(dec_seen), 0);
      for (int k = 0; k < 2; k++) begin
         rd(24'hFF0000, d);
         chk("R7 data", 32'(d), 32'(exp_dec));
         exp_dec++;
      end
      rd(24'hFF0000, d);
      chk("R8 count two ends", 32'(d), 32'(rom_fn(24'h7F0000)));

      // R6 clear with mask A zero
      wr(24'h004801, 8'h08);
      wr(24'h004800, 8'h00);
      start_seen = 0;
      wr(24'h004801, 8'h08);
      chk("R6 no arm with mask A clear", 32'(start_seen), 0);
      rd(24'hFF0000, d);
      chk("R6 cleared trigger", 32'(dec_seen), 0);

      // R11 unmapped
      rd(24'h400000, d);
      chk("R11 unmapped data", 32'(d), 0);
      chk("R11 no ROM request", 32'(rom_seen), 0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule